// File: doc/BRIEF.md
# Vector predicate lane-mask expander

This block is the predicate-to-mask stage of a wide vector datapath. A vector holds 128 bytes. Its predicate holds one bit per byte. The block turns that predicate into per-byte select masks and uses them to merge two vector sources into one result. The lanes can be 8, 16 or 32 bits wide. A lane of 16 or 32 bits takes each of its bytes from either source on its own. So one wide lane can be built from a mix of bytes from both operands. An invert flag complements the predicate, for the merge only.

The same predicate can be read and changed one bit at a time. The read port gives one bit chosen by a 7-bit index, taken from the predicate as it enters. The write port clears the indexed position, ORs in a new one-bit value and presents the updated predicate on its own output. The merge in the same evaluation uses that updated predicate. The block holds no state. It is pure combinational logic between a predicate register and the vector register file, which lie outside it.

Top module: `vpred_lane_merge`

## Requirements
- R1: With `lane_sel` = 0 (8-bit lanes), result byte i equals byte i of `src_yes` when bit i of the effective predicate is 1, and byte i of `src_no` when it is 0. Byte i occupies result bits 8i+7..8i.
- R2: With `lane_sel` = 1 (16-bit lanes), halfword lane k takes its low byte by predicate bit 2k and its high byte by bit 2k+1. It computes (mask & yes) | (inverted-predicate mask & no), so one halfword may mix bytes from both sources.
- R3: With `lane_sel` = 2 (32-bit lanes), word lane k takes bytes 0..3, lowest first, by predicate bits 4k..4k+3, with the same AND-OR merge.
- R4: `lane_sel` = 3 gives exactly the 8-bit lane result.
- R5: With `pred_invert` = 1, the effective predicate is the complement of the updated predicate, so a 0 bit selects `src_yes`.
- R6: `bit_rd` equals bit `bit_idx` of `pred_in`. Index bits 6..5 pick the 32-bit predicate word and bits 4..0 pick the position in it. The read sees the predicate before any write.
- R7: With `bit_wr_en` = 1, `pred_upd` equals `pred_in` with bit `bit_idx` replaced by `bit_wr_val` and every other bit unchanged. With `bit_wr_en` = 0, `pred_upd` equals `pred_in` whatever `bit_wr_val` is.
- R8: The merge uses the updated predicate, so a bit written in the same evaluation already steers its byte.
- R9: `pred_invert` has no effect on `pred_upd` or on `bit_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pred_in | input | 128 | Predicate, one bit per byte lane |
| src_yes | input | 1024 | Source taken where the effective predicate bit is 1 |
| src_no | input | 1024 | Source taken where the effective predicate bit is 0 |
| lane_sel | input | 2 | Lane width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 8-bit |
| pred_invert | input | 1 | Complement the predicate before the merge |
| bit_idx | input | 7 | Index of the predicate bit to read or write |
| bit_wr_en | input | 1 | Apply the single-bit write |
| bit_wr_val | input | 1 | Value written to the indexed bit |
| vec_out | output | 1024 | Merged vector |
| pred_upd | output | 128 | Predicate after the single-bit write |
| bit_rd | output | 1 | Indexed bit of the incoming predicate |

## Verification
The single-bit write and the lane merge can act in the same evaluation. The written bit must steer its byte at once, while the read port still shows the old value. The bench provokes this in three ways:
- writing a 1 into an all-zero predicate,
- writing a 0 into an all-one predicate,
- doing the same with inversion on.

In each case it checks that only the target byte changes source, that `bit_rd` keeps the old value and that `pred_upd` is unaffected by inversion. Randomised rounds mix writes, every lane width and inversion, and compare all three outputs against a model written from the requirements.

// File: rtl/vpx_pkg.sv
// Shared constants and lane-width encoding for the predicate lane-mask expander.
package vpx_pkg;
    // Width of one predicate storage word; a predicate bit index splits into word and position.
    localparam int PRED_WORD_W = 32;

    // Lane width select encoding; the spare code behaves as byte lanes.
    typedef enum logic [1:0] {
        LW_BYTE  = 2'd0,
        LW_HALF  = 2'd1,
        LW_WORD  = 2'd2,
        LW_SPARE = 2'd3
    } lane_w_e;
endpackage

// File: rtl/vpred_bit_port.sv
// Single-bit predicate access.
// Reads one predicate bit by index and produces the predicate with that bit
// replaced. The index splits into a storage word (upper bits) and a
// position within the word (lower bits). The write clears the position and
// then ORs in the new value, masked to one bit.
// Assumes NB is a multiple of 2*PRED_WORD_W. Purely combinational.
module vpred_bit_port #(
    parameter  int NB = 128,
    localparam int WW = vpx_pkg::PRED_WORD_W,
    localparam int IW = $clog2(NB),
    localparam int PW = $clog2(WW),
    localparam int NW = NB / WW,
    localparam int SW = IW - PW
) (
    input  logic [NB-1:0] pred_in,
    input  logic [IW-1:0] idx,
    input  logic          wr_en,
    input  logic          wr_val,
    output logic          rd_bit,
    output logic [NB-1:0] pred_upd
);
    logic [WW-1:0] word_q [NW];
    logic [SW-1:0] wsel;
    logic [PW-1:0] pos;
    logic [WW-1:0] tgt_word;

    // Slice the flat predicate into storage words.
    for (genvar w = 0; w < NW; w++) begin : g_split
        assign word_q[w] = pred_in[w*WW +: WW];
    end

    assign wsel = idx[IW-1:PW];
    assign pos  = idx[PW-1:0];

    // Read the addressed bit of the addressed word (pre-write value).
    always_comb rd_bit = word_q[wsel][pos];

    // Clear the target position, then OR in the one-bit new value.
    always_comb begin
        tgt_word = word_q[wsel] & ~({{(WW-1){1'b0}}, 1'b1} << pos);
        tgt_word = tgt_word | ({{(WW-1){1'b0}}, wr_val & 1'b1} << pos);
    end

    // Rebuild the predicate, replacing only the addressed word on a write.
    for (genvar w = 0; w < NW; w++) begin : g_join
        assign pred_upd[w*WW +: WW] = (wr_en && (wsel == SW'(w))) ? tgt_word : word_q[w];
    end
endmodule

// File: rtl/vpred_mask_expand.sv
// Predicate-to-byte-mask expansion for one lane width.
// Each lane of LANE_BYTES bytes takes LANE_BYTES consecutive predicate bits.
// Bit b of the lane becomes 0xFF or 0x00 in byte b of that lane, lowest
// byte first. Purely combinational.
module vpred_mask_expand #(
    parameter  int NB         = 128,
    parameter  int LANE_BYTES = 1,
    localparam int VW         = NB * 8,
    localparam int LANES      = NB / LANE_BYTES
) (
    input  logic [NB-1:0] pred,
    output logic [VW-1:0] byte_mask
);
    // Build every lane from its own predicate group.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
            localparam int BI = k * LANE_BYTES + b;
            assign byte_mask[BI*8 +: 8] = pred[BI] ? 8'hFF : 8'h00;
        end
    end
endmodule

// File: rtl/vpred_byte_merge.sv
// Lane merge of two vector sources.
// Byte mode: each byte is picked directly by its predicate bit.
// Wide-lane mode: result = (mask & yes) | (mask_n & no), where mask_n is
// expanded from the inverted predicate. Purely combinational.
module vpred_byte_merge #(
    parameter  int NB = 128,
    localparam int VW = NB * 8
) (
    input  logic [NB-1:0] pred,
    input  logic [VW-1:0] mask,
    input  logic [VW-1:0] mask_n,
    input  logic          byte_mode,
    input  logic [VW-1:0] src_yes,
    input  logic [VW-1:0] src_no,
    output logic [VW-1:0] merged
);
    logic [VW-1:0] by_bit;
    logic [VW-1:0] by_mask;

    // Per-byte conditional pick for 8-bit lanes.
    for (genvar i = 0; i < NB; i++) begin : g_pick
        assign by_bit[i*8 +: 8] = pred[i] ? src_yes[i*8 +: 8] : src_no[i*8 +: 8];
    end

    // AND-OR merge for 16- and 32-bit lanes.
    assign by_mask = (mask & src_yes) | (mask_n & src_no);

    // Choose the merge form for the current lane width.
    always_comb merged = byte_mode ? by_bit : by_mask;
endmodule

// File: rtl/vpred_lane_merge.sv
// Vector predicate lane-mask expander (top).
// Applies an optional single-bit write to the incoming predicate. Then it
// optionally inverts the result. It expands the result into byte masks for
// 8-, 16- and 32-bit lanes and merges two vector sources by the selected
// width. The read port returns the pre-write bit. No state is held, so no
// clock or reset is needed; the surrounding pipeline registers the result.
module vpred_lane_merge #(
    parameter  int VEC_LOG2 = 7,
    localparam int NB       = 1 << VEC_LOG2,
    localparam int VW       = NB * 8,
    localparam int IW       = VEC_LOG2
) (
    input  logic [NB-1:0] pred_in,
    input  logic [VW-1:0] src_yes,
    input  logic [VW-1:0] src_no,
    input  logic [1:0]    lane_sel,
    input  logic          pred_invert,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_wr_en,
    input  logic          bit_wr_val,
    output logic [VW-1:0] vec_out,
    output logic [NB-1:0] pred_upd,
    output logic          bit_rd
);
    import vpx_pkg::*;

    localparam int NWIDTH = 3;

    logic [NB-1:0] eff_pred;
    logic [VW-1:0] mask_g   [NWIDTH];
    logic [VW-1:0] mask_n_g [NWIDTH];
    logic [VW-1:0] mask_sel;
    logic [VW-1:0] mask_n_sel;
    logic          byte_mode;
    lane_w_e       lw;

    vpred_bit_port #(.NB(NB)) u_bits (
        .pred_in  (pred_in),
        .idx      (bit_idx),
        .wr_en    (bit_wr_en),
        .wr_val   (bit_wr_val),
        .rd_bit   (bit_rd),
        .pred_upd (pred_upd)
    );

    // Effective predicate for the merge: updated value, optionally complemented.
    always_comb eff_pred = pred_invert ? ~pred_upd : pred_upd;

    // One expander pair per lane width (1, 2 and 4 bytes): direct and inverted.
    for (genvar g = 0; g < NWIDTH; g++) begin : g_width
        vpred_mask_expand #(.NB(NB), .LANE_BYTES(1 << g)) u_mx (
            .pred      (eff_pred),
            .byte_mask (mask_g[g])
        );
        vpred_mask_expand #(.NB(NB), .LANE_BYTES(1 << g)) u_mx_n (
            .pred      (~eff_pred),
            .byte_mask (mask_n_g[g])
        );
    end

    assign lw = lane_w_e'(lane_sel);

    // Pick the mask pair and merge form for the selected lane width.
    always_comb begin
        byte_mode  = 1'b0;
        mask_sel   = mask_g[0];
        mask_n_sel = mask_n_g[0];
        unique case (lw)
            LW_HALF: begin
                mask_sel   = mask_g[1];
                mask_n_sel = mask_n_g[1];
            end
            LW_WORD: begin
                mask_sel   = mask_g[2];
                mask_n_sel = mask_n_g[2];
            end
            LW_BYTE, LW_SPARE: byte_mode = 1'b1;
            default: byte_mode = 1'b1;
        endcase
    end

    vpred_byte_merge #(.NB(NB)) u_merge (
        .pred      (eff_pred),
        .mask      (mask_sel),
        .mask_n    (mask_n_sel),
        .byte_mode (byte_mode),
        .src_yes   (src_yes),
        .src_no    (src_no),
        .merged    (vec_out)
    );
endmodule

// File: rtl/vpred_lane_merge_chk.sv
// Property checker for the lane-mask expander, bound to the top.
// The block is combinational, so the checks are immediate assertions on
// settled port values. They use a flat-index formulation of each requirement.
module vpred_lane_merge_chk #(
    parameter  int VEC_LOG2 = 7,
    localparam int NB       = 1 << VEC_LOG2,
    localparam int VW       = NB * 8,
    localparam int IW       = VEC_LOG2
) (
    input logic [NB-1:0] pred_in,
    input logic [VW-1:0] src_yes,
    input logic [VW-1:0] src_no,
    input logic [1:0]    lane_sel,
    input logic          pred_invert,
    input logic [IW-1:0] bit_idx,
    input logic          bit_wr_en,
    input logic          bit_wr_val,
    input logic [VW-1:0] vec_out,
    input logic [NB-1:0] pred_upd,
    input logic          bit_rd
);
    logic [VW-1:0] want;
    logic [NB-1:0] sel_bits;

    // Expected merge from the post-write predicate, same rule for every width.
    always_comb begin
        sel_bits = pred_upd ^ {NB{pred_invert}};
        for (int i = 0; i < NB; i++) begin
            want[i*8 +: 8] = sel_bits[i] ? src_yes[i*8 +: 8] : src_no[i*8 +: 8];
        end
    end

    // Port-level property checks.
    always_comb begin
        // R1 R2 R3 R4 R5 R8
        merge_by_byte_chk: assert (vec_out == want)
            else $error("merge mismatch, lane_sel=%0d", lane_sel);
        // R6
        rd_pre_write_chk: assert (bit_rd == pred_in[bit_idx])
            else $error("read bit mismatch");
        // R7
        upd_hold_chk: assert (bit_wr_en || (pred_upd == pred_in))
            else $error("predicate changed without write");
        // R7
        upd_target_chk: assert (!bit_wr_en || (pred_upd[bit_idx] == bit_wr_val))
            else $error("written bit wrong");
        // R7
        upd_single_chk: assert ($countones(pred_upd ^ pred_in) <= 1)
            else $error("write touched more than one bit");
    end
endmodule

bind vpred_lane_merge vpred_lane_merge_chk #(.VEC_LOG2(VEC_LOG2)) u_chk (
    .pred_in     (pred_in),
    .src_yes     (src_yes),
    .src_no      (src_no),
    .lane_sel    (lane_sel),
    .pred_invert (pred_invert),
    .bit_idx     (bit_idx),
    .bit_wr_en   (bit_wr_en),
    .bit_wr_val  (bit_wr_val),
    .vec_out     (vec_out),
    .pred_upd    (pred_upd),
    .bit_rd      (bit_rd)
);

// File: tb/vpred_lane_merge_test.sv
// Scoreboard bench: driver pushes expected results, monitor checks them.
module vpred_lane_merge_test;
    localparam int NB = 128;
    localparam int VW = NB * 8;

    typedef struct {
        string          tag;
        logic [VW-1:0]  out;
        logic [NB-1:0]  upd;
        logic           rd;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NB-1:0] pred_in = '0;
    logic [VW-1:0] src_yes = '0;
    logic [VW-1:0] src_no = '0;
    logic [1:0]    lane_sel = 2'd0;
    logic          pred_invert = 1'b0;
    logic [6:0]    bit_idx = '0;
    logic          bit_wr_en = 1'b0;
    logic          bit_wr_val = 1'b0;
    logic [VW-1:0] vec_out;
    logic [NB-1:0] pred_upd;
    logic          bit_rd;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    vpred_lane_merge uut (
        .pred_in(pred_in), .src_yes(src_yes), .src_no(src_no),
        .lane_sel(lane_sel), .pred_invert(pred_invert), .bit_idx(bit_idx),
        .bit_wr_en(bit_wr_en), .bit_wr_val(bit_wr_val),
        .vec_out(vec_out), .pred_upd(pred_upd), .bit_rd(bit_rd)
    );

    // Drive one stimulus after a rising edge and queue its expected result.
    task automatic drive(input string tag, input logic [NB-1:0] p, input logic [1:0] sel,
                         input logic inv, input logic [6:0] idx, input logic wen,
                         input logic wval, input logic [VW-1:0] y, input logic [VW-1:0] n);
        exp_t e;
        logic [NB-1:0] u;
        @(posedge clk);
        #1;
        pred_in = p; lane_sel = sel; pred_invert = inv; bit_idx = idx;
        bit_wr_en = wen; bit_wr_val = wval; src_yes = y; src_no = n;
        u = p;
        if (wen) u[idx] = wval;
        e.tag = tag; e.upd = u; e.rd = p[idx];
        for (int i = 0; i < NB; i++)
            e.out[i*8 +: 8] = ((u[i] ^ inv) == 1'b1) ? y[i*8 +: 8] : n[i*8 +: 8];
        sb_q.push_back(e);
    endtask

    // Monitor: compare settled outputs on the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks += 3;
            if (vec_out !== e.out) begin
                fails++;
                $display("FAIL %s vec_out act=%h exp=%h", e.tag, vec_out, e.out);
            end
            if (pred_upd !== e.upd) begin
                fails++;
                $display("FAIL %s pred_upd act=%h exp=%h", e.tag, pred_upd, e.upd);
            end
            if (bit_rd !== e.rd) begin
                fails++;
                $display("FAIL %s bit_rd act=%b exp=%b", e.tag, bit_rd, e.rd);
            end
        end
    end

    function automatic logic [NB-1:0] rnd_pred();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        logic [VW-1:0] ya, na;
        for (int i = 0; i < NB; i++) begin
            ya[i*8 +: 8] = 8'(i);
            na[i*8 +: 8] = ~8'(i);
        end
        // R7 idle: all inputs zero during reset
        drive("R7 idle", '0, 2'd0, 1'b0, 7'd0, 1'b0, 1'b0, '0, '0);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R1 alternating byte predicate
        drive("R1", {64{2'b01}}, 2'd0, 1'b0, 7'd3, 1'b0, 1'b0, ya, na);
        drive("R1", rnd_pred(), 2'd0, 1'b0, 7'd9, 1'b0, 1'b0, ya, na);
        // R2 mixed bytes inside halfwords
        drive("R2", {64{2'b01}}, 2'd1, 1'b0, 7'd0, 1'b0, 1'b0, ya, na);
        drive("R2", {64{2'b10}}, 2'd1, 1'b0, 7'd0, 1'b0, 1'b0, ya, na);
        // R3 mixed bytes inside words, low byte first
        drive("R3", {32{4'b0110}}, 2'd2, 1'b0, 7'd0, 1'b0, 1'b0, ya, na);
        drive("R3", {32{4'b1000}}, 2'd2, 1'b0, 7'd0, 1'b0, 1'b0, ya, na);
        // R4 spare code behaves as bytes
        drive("R4", {32{4'b1101}}, 2'd3, 1'b0, 7'd0, 1'b0, 1'b0, ya, na);
        // R5 inverted predicate
        drive("R5", {32{4'b0001}}, 2'd2, 1'b1, 7'd0, 1'b0, 1'b0, ya, na);
        drive("R5", '1, 2'd0, 1'b1, 7'd0, 1'b0, 1'b0, ya, na);
        // R6 reads at word boundaries
        drive("R6", 128'h1, 2'd0, 1'b0, 7'd0, 1'b0, 1'b0, ya, na);
        drive("R6", 128'h8000_0000, 2'd0, 1'b0, 7'd31, 1'b0, 1'b0, ya, na);
        drive("R6", 128'h1_0000_0000, 2'd0, 1'b0, 7'd32, 1'b0, 1'b0, ya, na);
        drive("R6", {1'b1, 127'd0}, 2'd1, 1'b0, 7'd127, 1'b0, 1'b0, ya, na);
        drive("R6", ~128'h8000_0000, 2'd0, 1'b0, 7'd31, 1'b0, 1'b0, ya, na);
        // R7 writes: set top bit, clear a middle bit, write ignored when disabled
        drive("R7", '0, 2'd0, 1'b0, 7'd127, 1'b1, 1'b1, ya, na);
        drive("R7", '1, 2'd2, 1'b0, 7'd64, 1'b1, 1'b0, ya, na);
        drive("R7", '0, 2'd0, 1'b0, 7'd40, 1'b0, 1'b1, ya, na);
        // R8 write steers its byte in the same evaluation; read sees the old bit
        drive("R8", '0, 2'd0, 1'b0, 7'd5, 1'b1, 1'b1, ya, na);
        drive("R8", '1, 2'd2, 1'b0, 7'd33, 1'b1, 1'b0, ya, na);
        // R9 inversion leaves the updated predicate and read bit alone
        drive("R9", {64{2'b10}}, 2'd1, 1'b1, 7'd6, 1'b1, 1'b1, ya, na);
        // Random mix of all functions
        for (int r = 0; r < 60; r++) begin
            drive("R1 R2 R3 R7 rand", rnd_pred(), 2'($urandom), 1'($urandom),
                  7'($urandom), 1'($urandom), 1'($urandom), rnd_vec(), rnd_vec());
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule